// File: doc/BRIEF.md
# Grouped XNOR-Popcount Binary Neuron

This block evaluates one binarized 3x3 convolution position for every output channel in parallel. Each activation bit and each weight bit stands for a value of +1 (bit 1) or -1 (bit 0). An XNOR of an activation bit and its weight bit is their signed product. A popcount of the agreeing positions gives the signed dot product without any multiplier: sum = 2*agreements - N, where N = GROUP_CH*9.

Input channels are split into `GROUPS` contiguous groups of `GROUP_CH` channels. The output channels are split evenly across the groups, so each output channel sees only the window of its own group. Batch normalisation is folded into a per-channel signed threshold kept in a small register bank, which is loaded through a write port. The output bit of a channel is 1 when the signed sum is at least its threshold. The bits of all channels leave together as a new activation word.

Inputs are accepted with a valid/ready handshake. Results come out on a second valid/ready handshake after a two-stage pipeline. The pipeline holds its contents under backpressure.

Top module: `bnn_neuron`

## Requirements
- R1: A tap counts as an agreement (+1) when its activation bit equals its weight bit, and as -1 otherwise. With every tap agreeing, the sum is +N. With every tap disagreeing, the sum is -N.
- R2: Output bit o of `out_act` is 1 exactly when (2*agreements - N) >= threshold[o]. Equality gives 1.
- R3: Activation bits are laid out with the bit of channel c, tap t (t = row*3+col) at index c*9+t. Output o belongs to group o/(OUT_CH/GROUPS) and reads only channels g*GROUP_CH to g*GROUP_CH+GROUP_CH-1 of that group g. Changing another group's bits leaves bit o unchanged.
- R4: Weight bits for output o, local channel k, tap t sit at index o*N + k*9 + t. The result of an input accepted at clock edge k is on the output with `out_valid` high after edge k+1.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_act` hold, and `in_ready` is low.
- R6: A write with `thr_we` high stores the signed two's-complement `thr_data` as the threshold of channel `thr_addr`. All thresholds reset to 0.
- R7: During and after reset, `out_valid` is low and `in_ready` is high.
- R8: A threshold of -N forces a 1 for any window. A threshold of N+1 forces a 0 for any window.
- R9: With `out_ready` held high, one input is accepted every cycle, and results leave on consecutive cycles in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input window valid |
| in_ready | output | 1 | Block can take an input window |
| act_win | input | GROUPS*GROUP_CH*9 | Activation bits, channel-major, tap-minor |
| wgt_win | input | OUT_CH*GROUP_CH*9 | Kernel weight bits, per output channel |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes the result |
| out_act | output | OUT_CH | One binary activation per output channel |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | $clog2(OUT_CH) | Threshold channel index |
| thr_data | input | THR_W | Signed threshold value |

## Verification
The hardest case to reach from the ports is a tie, where the signed sum lands exactly on the threshold at both ends of the range. Most random windows fall near zero, so ties at +N and -N never come up by chance. The stimulus sets the activation window equal to the weights, or to their complement, to pin the sum at +N or -N. It then writes thresholds on and one step beyond those values. Group isolation is reached by flipping one group's inputs and checking that the other groups' output bits stay the same.

// File: rtl/bnn_pkg.sv
package bnn_pkg;
  localparam int KTAPS = 9;

  // signed dot product of +/-1 vectors from an agreement count
  function automatic int signed_dot(input int agree, input int n);
    return 2 * agree - n;
  endfunction

  // sign(x - tau) with ties mapped to +1
  function automatic logic fires(input int agree, input int n, input int thr);
    return signed_dot(agree, n) >= thr;
  endfunction
endpackage

// File: rtl/bnn_xnor_pop.sv
module bnn_xnor_pop #(
  parameter int N  = 36,
  parameter int CW = 6
) (
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  w,
  output logic [CW-1:0] agree
);
  logic [N-1:0] prod;
  assign prod = a ~^ w;

  always_comb begin
    agree = '0;
    for (int i = 0; i < N; i++) begin
      agree = agree + CW'(prod[i]);
    end
  end
endmodule

// File: rtl/bnn_thr_bank.sv
module bnn_thr_bank #(
  parameter int CH = 16,
  parameter int TW = 8,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [TW-1:0]    data,
  output logic [CH*TW-1:0] thr_flat
);
  logic [TW-1:0] thr_q [CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) thr_q[i] <= '0;
    end else if (we) begin
      thr_q[addr] <= data;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_flat
    assign thr_flat[c*TW +: TW] = thr_q[c];
  end
endmodule

// File: rtl/bnn_sign_cmp.sv
module bnn_sign_cmp #(
  parameter int N  = 36,
  parameter int CW = 6,
  parameter int TW = 8
) (
  input  logic [CW-1:0] agree,
  input  logic [TW-1:0] thr,
  output logic          fire
);
  int thr_i;
  assign thr_i = int'($signed(thr));
  assign fire  = bnn_pkg::fires(int'(agree), N, thr_i);
endmodule

// File: rtl/bnn_neuron.sv
module bnn_neuron #(
  parameter int GROUP_CH = 4,
  parameter int GROUPS   = 4,
  parameter int OUT_CH   = 16,
  parameter int THR_W    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic [GROUPS*GROUP_CH*9-1:0]          act_win,
  input  logic [OUT_CH*GROUP_CH*9-1:0]          wgt_win,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [OUT_CH-1:0]                     out_act,
  input  logic                                  thr_we,
  input  logic [$clog2(OUT_CH)-1:0]             thr_addr,
  input  logic [THR_W-1:0]                      thr_data
);
  localparam int N   = GROUP_CH * bnn_pkg::KTAPS;
  localparam int CW  = $clog2(N + 1);
  localparam int OPG = OUT_CH / GROUPS;
  localparam int AW  = $clog2(OUT_CH);

  logic              adv;
  logic              accept;
  logic              s1_valid;
  logic [CW-1:0]     agree_d [OUT_CH];
  logic [CW-1:0]     agree_q [OUT_CH];
  logic [OUT_CH-1:0] fire;
  logic [OUT_CH*THR_W-1:0] thr_flat;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign accept   = in_valid && adv;

  bnn_thr_bank #(.CH(OUT_CH), .TW(THR_W), .AW(AW)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (thr_we),
    .addr     (thr_addr),
    .data     (thr_data),
    .thr_flat (thr_flat)
  );

  for (genvar o = 0; o < OUT_CH; o++) begin : g_ch
    localparam int GRP = o / OPG;
    bnn_xnor_pop #(.N(N), .CW(CW)) u_pop (
      .a     (act_win[GRP*N +: N]),
      .w     (wgt_win[o*N +: N]),
      .agree (agree_d[o])
    );
    bnn_sign_cmp #(.N(N), .CW(CW), .TW(THR_W)) u_cmp (
      .agree (agree_q[o]),
      .thr   (thr_flat[o*THR_W +: THR_W]),
      .fire  (fire[o])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
      out_act   <= '0;
      for (int i = 0; i < OUT_CH; i++) agree_q[i] <= '0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (in_valid) agree_q <= agree_d;
      if (s1_valid) out_act <= fire;
    end
  end
endmodule

// File: rtl/bnn_neuron_chk.sv
module bnn_neuron_chk #(
  parameter int OUT_CH = 16,
  parameter int THR_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [OUT_CH-1:0]         out_act,
  input logic                      thr_we,
  input logic [$clog2(OUT_CH)-1:0] thr_addr,
  input logic [THR_W-1:0]          thr_data,
  input logic [OUT_CH*THR_W-1:0]   thr_flat
);
  // R5
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_act)));

  // R5
  no_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);

  // R6
  thr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (thr_flat[$past(thr_addr)*THR_W +: THR_W] == $past(thr_data)));

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

  // R7
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind bnn_neuron bnn_neuron_chk #(.OUT_CH(OUT_CH), .THR_W(THR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_act   (out_act),
  .thr_we    (thr_we),
  .thr_addr  (thr_addr),
  .thr_data  (thr_data),
  .thr_flat  (thr_flat)
);

// File: tb/bnn_neuron_bench.sv
module bnn_neuron_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GC   = 4;
  localparam int GRPS = 4;
  localparam int OC   = 16;
  localparam int TW   = 8;
  localparam int NN   = GC * 9;
  localparam int OPG  = OC / GRPS;
  localparam int AWID = GRPS * GC * 9;
  localparam int WWID = OC * NN;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [AWID-1:0] act_win = '0;
  logic [WWID-1:0] wgt_win = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [OC-1:0] out_act;
  logic thr_we = 0;
  logic [3:0] thr_addr = '0;
  logic [TW-1:0] thr_data = '0;

  int checks = 0;
  int fails  = 0;
  int thr_m [OC];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnn_neuron #(.GROUP_CH(GC), .GROUPS(GRPS), .OUT_CH(OC), .THR_W(TW)) u_bnn_neuron (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .act_win(act_win), .wgt_win(wgt_win), .out_valid(out_valid),
    .out_ready(out_ready), .out_act(out_act), .thr_we(thr_we),
    .thr_addr(thr_addr), .thr_data(thr_data)
  );

  // reference: sum = N minus twice the number of mismatching taps
  function automatic logic [OC-1:0] model(input logic [AWID-1:0] a, input logic [WWID-1:0] w);
    logic [OC-1:0] r;
    for (int o = 0; o < OC; o++) begin
      int mism = 0;
      int g = o / OPG;
      for (int k = 0; k < GC; k++)
        for (int t = 0; t < 9; t++)
          if (a[(g*GC + k)*9 + t] != w[o*NN + k*9 + t]) mism++;
      r[o] = ((NN - 2*mism) >= thr_m[o]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [OC-1:0] got, input logic [OC-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk1(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic wr_thr(input int ch, input int val);
    @(negedge clk);
    thr_we = 1; thr_addr = 4'(ch); thr_data = TW'(val);
    @(negedge clk);
    thr_we = 0;
    thr_m[ch] = val;
  endtask

  task automatic wr_all(input int val);
    for (int c = 0; c < OC; c++) wr_thr(c, val);
  endtask

  function automatic logic [AWID-1:0] rnd_act();
    logic [AWID-1:0] v;
    for (int i = 0; i < AWID; i++) v[i] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  function automatic logic [WWID-1:0] rnd_wgt();
    logic [WWID-1:0] v;
    for (int i = 0; i < WWID; i++) v[i] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  // activation equal to each channel's weights (needs weights shared per group)
  function automatic logic [WWID-1:0] wgt_from_act(input logic [AWID-1:0] a);
    logic [WWID-1:0] w;
    for (int o = 0; o < OC; o++) w[o*NN +: NN] = a[(o/OPG)*NN +: NN];
    return w;
  endfunction

  // send one window with out_ready high; R4 latency checked on the way
  task automatic run1(input logic [AWID-1:0] a, input logic [WWID-1:0] w, output logic [OC-1:0] res);
    @(negedge clk);
    act_win = a; wgt_win = w; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk1("R4 not early", out_valid, 1'b0);
    @(negedge clk);
    chk1("R4 valid at second edge", out_valid, 1'b1);
    res = out_act;
  endtask

  task automatic t_reset();
    chk1("R7 out_valid in reset", out_valid, 1'b0);
    chk1("R7 in_ready in reset", in_ready, 1'b1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk1("R7 out_valid after reset", out_valid, 1'b0);
    chk1("R7 in_ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_reset_thr();
    logic [AWID-1:0] a;
    logic [OC-1:0] r;
    a = rnd_act();
    run1(a, wgt_from_act(a), r);
    chk("R6 reset thr zero, all agree", r, '1);
    run1(~a, wgt_from_act(a), r);
    chk("R6 reset thr zero, all disagree", r, '0);
  endtask

  task automatic t_ties();
    logic [AWID-1:0] a;
    logic [OC-1:0] r;
    a = rnd_act();
    wr_all(NN);
    run1(a, wgt_from_act(a), r);
    chk("R1 R2 tie at +N", r, '1);
    wr_all(NN + 1);
    run1(a, wgt_from_act(a), r);
    chk("R8 thr N+1 all agree", r, '0);
    run1(rnd_act(), rnd_wgt(), r);
    chk("R8 thr N+1 random", r, '0);
    wr_all(-NN);
    run1(~a, wgt_from_act(a), r);
    chk("R1 R8 tie at -N", r, '1);
    run1(rnd_act(), rnd_wgt(), r);
    chk("R8 thr -N random", r, '1);
    wr_all(-NN + 1);
    run1(~a, wgt_from_act(a), r);
    chk("R2 one above -N", r, '0);
  endtask

  task automatic t_mixed();
    logic [AWID-1:0] a;
    logic [WWID-1:0] w;
    logic [OC-1:0] r;
    for (int c = 0; c < OC; c++) wr_thr(c, (c % 7) * 2 - 6);
    for (int n = 0; n < 20; n++) begin
      a = rnd_act(); w = rnd_wgt();
      run1(a, w, r);
      chk("R2 R3 R4 random window", r, model(a, w));
    end
  endtask

  task automatic t_group();
    logic [AWID-1:0] a, a2;
    logic [WWID-1:0] w;
    logic [OC-1:0] r1, r2, mask;
    for (int c = 0; c < OC; c++) wr_thr(c, 0);
    for (int g = 0; g < GRPS; g++) begin
      a = rnd_act(); w = rnd_wgt();
      run1(a, w, r1);
      a2 = a;
      a2[g*NN +: NN] = ~a[g*NN +: NN];
      run1(a2, w, r2);
      mask = '0;
      for (int o = 0; o < OC; o++) if (o / OPG == g) mask[o] = 1'b1;
      chk("R3 other groups unchanged", r2 & ~mask, r1 & ~mask);
      chk("R3 flipped group follows model", r2, model(a2, w));
    end
  endtask

  task automatic t_stall();
    logic [AWID-1:0] a1, a2;
    logic [WWID-1:0] w;
    logic [OC-1:0] e1, e2;
    a1 = rnd_act(); a2 = rnd_act(); w = rnd_wgt();
    e1 = model(a1, w); e2 = model(a2, w);
    @(negedge clk);
    out_ready = 0; act_win = a1; wgt_win = w; in_valid = 1;
    @(negedge clk);
    act_win = a2;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk1("R5 valid while stalled", out_valid, 1'b1);
    chk("R5 first result", out_act, e1);
    in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk1("R5 in_ready low", in_ready, 1'b0);
      chk("R5 out_act held", out_act, e1);
    end
    out_ready = 1;
    @(negedge clk);
    chk1("R5 second queued result", out_valid, 1'b1);
    chk("R5 second result", out_act, e2);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    chk("R5 third result", out_act, e2);
    @(negedge clk);
    chk1("R5 drained", out_valid, 1'b0);
  endtask

  task automatic t_stream();
    logic [AWID-1:0] av [3];
    logic [WWID-1:0] w;
    w = rnd_wgt();
    for (int i = 0; i < 3; i++) av[i] = rnd_act();
    wgt_win = w;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        chk1("R9 back-to-back valid", out_valid, 1'b1);
        chk("R9 in-order result", out_act, model(av[c-2], w));
      end
      if (c < 3) begin
        chk1("R9 ready each cycle", in_ready, 1'b1);
        act_win = av[c]; in_valid = 1;
      end else begin
        in_valid = 0;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < OC; c++) thr_m[c] = 0;
    #(CLK_PERIOD*2 + 1);
    t_reset();
    t_reset_thr();
    t_ties();
    t_mixed();
    t_group();
    t_stall();
    t_stream();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule